// File: doc/BRIEF.md
# Serial Transfer Interrupt Generator

This block watches the serial clock of a byte-oriented shift-register channel and decides when to raise a transfer-complete interrupt. The channel runs in one of three modes: a plain clocked serial link (three- or two-wire), I2C transmit, or I2C receive. A two-bit wait field chooses whether the request lands after the eighth or the ninth serial clock. In receive mode the block can also drive the acknowledge bit by itself during the ninth clock.

With the wake-up bit set in receive mode, the block enters address-match mode. After each start condition it compares the first received byte with a programmed slave address. It raises an interrupt only when they match, and otherwise ignores the bus until the next start condition. A stop condition also raises an interrupt in this mode.

Every control combination that the current mode does not allow raises a setting-error flag, and all interrupt activity is held off while that flag is high. Start and stop detection, the shift register and the pin drivers are outside this block. Their results arrive as one-cycle strobes, a received-byte bus, and a raw serial-clock level that is synchronized inside.

Top module: `sti_irq_gen`

## Requirements
- R1: With `ser_mode`=00 (plain serial), the only legal setting is `busy_en`, `wake_en`, `wt_sel` and `ack_auto_en` all zero. In that setting `irq` pulses once for every 8 rising edges of `sclk_in`.
- R2: With `ser_mode`=01 (I2C transmit), the legal settings need `busy_en`=0, `wake_en`=0, `ack_auto_en`=0 and `wt_sel[1]`=1. `wt_sel[0]`=0 gives an interrupt every 8 clocks, and `wt_sel[0]`=1 gives one every 9 clocks.
- R3: With `ser_mode`=10 (I2C receive), `busy_en`=1 and `wt_sel[1]`=1 are required. With `wake_en`=0, `wt_sel[0]`=0 needs `ack_auto_en`=0 and gives 8 clocks per interrupt. With `wake_en`=0 and `wt_sel[0]`=1, `ack_auto_en` may be either value and the interrupt comes every 9 clocks.
- R4: Any other combination is prohibited, including every setting with `ser_mode`=11. From the clock edge after such a setting appears, and for as long as it stays, `set_err` is 1. During that time `irq` stays 0 and the clock count is cleared.
- R5: `irq` is a single system-clock pulse. It is high in the cycle after the third rising system-clock edge that follows the `sclk_in` rise that completes the count.
- R6: In the I2C modes, a `start_stb` clears the clock count. In plain serial mode `start_stb` has no effect on the count.
- R7: In receive mode with `wt_sel`=11 and `ack_auto_en`=1, `ack_drive` goes high on the 8th counted serial clock and drops on the 9th. It stays 0 in every other setting.
- R8: Address-match mode is `ser_mode`=10 with `busy_en`, `wake_en`, both `wt_sel` bits and `ack_auto_en` all 1. The byte on `rx_byte` at the 8th clock after a start is compared with `slave_addr`. On a match, `ack_drive` is driven and `irq` fires at the 9th clock, and later bytes interrupt every 9 clocks. On a mismatch there is no acknowledge and no interrupt until the next `start_stb`.
- R9: In address-match mode a `stop_stb` raises `irq` one cycle later and returns the block to waiting for a start. In the other modes `stop_stb` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 2 | 00 plain serial, 01 I2C transmit, 10 I2C receive, 11 prohibited |
| busy_en | input | 1 | Busy-enable control bit |
| wake_en | input | 1 | Wake-up (address-match) control bit |
| wt_sel | input | 2 | Wait-timing field; bit 1 enables waiting, bit 0 selects 9 clocks |
| ack_auto_en | input | 1 | Automatic acknowledge enable |
| sclk_in | input | 1 | Raw serial clock level, asynchronous |
| start_stb | input | 1 | One-cycle start-condition strobe |
| stop_stb | input | 1 | One-cycle stop-condition strobe |
| rx_byte | input | BYTE_BITS | Received shift-register contents |
| slave_addr | input | BYTE_BITS | Programmed slave address |
| irq | output | 1 | One-cycle interrupt request |
| set_err | output | 1 | Prohibited-setting flag |
| ack_drive | output | 1 | Automatic acknowledge drive during the ninth clock |

## Verification
A count that drifts, or that is not cleared, shows up as an interrupt one or more serial clocks early or late. It is therefore visible within one byte time, as a wrong number of `irq` pulses over a fixed run of clocks. A stuck address phase shows up in the same way, either as interrupts that should be missing after a mismatch or as missing interrupts after a match, by the ninth clock of the next byte. A wrong legality decode is visible one system clock after the setting is applied, on `set_err` and on suppressed pulses. The bench sweeps every control combination against a separately derived legality model for exactly this reason.

// File: rtl/sti_pkg.sv
package sti_pkg;

    typedef enum logic [1:0] {
        MODE_SIO  = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX   = 2'b10,
        MODE_RSVD = 2'b11
    } ser_mode_e;

    typedef enum logic [1:0] {
        AP_IDLE = 2'b00,
        AP_ADDR = 2'b01,
        AP_DATA = 2'b10
    } addr_phase_e;

    // Decoded view of the control bits
    typedef struct packed {
        logic illegal;
        logic i2c;
        logic nine;
        logic auto_ack;
        logic addr_mode;
    } cfg_t;

endpackage

// File: rtl/sti_sync.sv
module sti_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sh_q[STAGES-1];
    end

    assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sti_decode.sv
module sti_decode
    import sti_pkg::*;
(
    input  logic [1:0] ser_mode,
    input  logic       busy_en,
    input  logic       wake_en,
    input  logic [1:0] wt_sel,
    input  logic       ack_auto_en,
    output cfg_t       cfg
);
    always_comb begin
        cfg         = '0;
        cfg.illegal = 1'b1;
        unique case (ser_mode_e'(ser_mode))
            MODE_SIO: begin
                if (!busy_en && !wake_en && wt_sel == 2'b00 && !ack_auto_en)
                    cfg.illegal = 1'b0;
            end
            MODE_TX: begin
                if (!busy_en && !wake_en && wt_sel[1] && !ack_auto_en) begin
                    cfg.illegal = 1'b0;
                    cfg.nine    = wt_sel[0];
                end
            end
            MODE_RX: begin
                if (busy_en && wt_sel[1]) begin
                    if (!wake_en) begin
                        if (!wt_sel[0]) begin
                            cfg.illegal = ack_auto_en;
                        end else begin
                            cfg.illegal  = 1'b0;
                            cfg.nine     = 1'b1;
                            cfg.auto_ack = ack_auto_en;
                        end
                    end else if (wt_sel[0] && ack_auto_en) begin
                        cfg.illegal   = 1'b0;
                        cfg.nine      = 1'b1;
                        cfg.auto_ack  = 1'b1;
                        cfg.addr_mode = 1'b1;
                    end
                end
            end
            default: ;
        endcase
        cfg.i2c = !cfg.illegal && (ser_mode_e'(ser_mode) != MODE_SIO);
        if (cfg.illegal) begin
            cfg.nine      = 1'b0;
            cfg.auto_ack  = 1'b0;
            cfg.addr_mode = 1'b0;
        end
    end
endmodule

// File: rtl/sti_irq_gen.sv
module sti_irq_gen
    import sti_pkg::*;
#(
    parameter int BYTE_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           ser_mode,
    input  logic                 busy_en,
    input  logic                 wake_en,
    input  logic [1:0]           wt_sel,
    input  logic                 ack_auto_en,
    input  logic                 sclk_in,
    input  logic                 start_stb,
    input  logic                 stop_stb,
    input  logic [BYTE_BITS-1:0] rx_byte,
    input  logic [BYTE_BITS-1:0] slave_addr,
    output logic                 irq,
    output logic                 set_err,
    output logic                 ack_drive
);
    localparam int CW = $clog2(BYTE_BITS + 2);
    localparam logic [CW-1:0] LAST_DATA = CW'(BYTE_BITS);
    localparam logic [CW-1:0] LAST_ACK  = CW'(BYTE_BITS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
        logic          err;
        logic          ack;
        addr_phase_e   aph;
        logic          match;
    } state_t;

    state_t        st_d, st_q;
    cfg_t          cfg;
    logic          sclk_rise;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] target;
    logic          addr_hit;

    sti_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sclk_in),
        .rise  (sclk_rise)
    );

    sti_decode dec_i (
        .ser_mode    (ser_mode),
        .busy_en     (busy_en),
        .wake_en     (wake_en),
        .wt_sel      (wt_sel),
        .ack_auto_en (ack_auto_en),
        .cfg         (cfg)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.err = cfg.illegal;
        cnt_inc  = st_q.cnt + 1'b1;
        target   = cfg.nine ? LAST_ACK : LAST_DATA;
        addr_hit = (rx_byte == slave_addr);

        if (cfg.illegal) begin
            st_d.cnt   = '0;
            st_d.ack   = 1'b0;
            st_d.aph   = AP_IDLE;
            st_d.match = 1'b0;
        end else if (cfg.i2c && start_stb) begin
            st_d.cnt   = '0;
            st_d.ack   = 1'b0;
            st_d.aph   = AP_ADDR;
            st_d.match = 1'b0;
        end else if (cfg.addr_mode && stop_stb) begin
            st_d.cnt   = '0;
            st_d.ack   = 1'b0;
            st_d.aph   = AP_IDLE;
            st_d.match = 1'b0;
            st_d.irq   = 1'b1;
        end else if (sclk_rise) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc == LAST_DATA) begin
                if (cfg.addr_mode && st_q.aph == AP_ADDR)
                    st_d.match = addr_hit;
                st_d.ack = !cfg.addr_mode || st_q.aph == AP_DATA ||
                           (st_q.aph == AP_ADDR && addr_hit);
            end
            if (cnt_inc == target) begin
                st_d.cnt = '0;
                st_d.ack = 1'b0;
                if (!cfg.addr_mode) begin
                    st_d.irq = 1'b1;
                end else begin
                    unique case (st_q.aph)
                        AP_DATA: st_d.irq = 1'b1;
                        AP_ADDR: begin
                            st_d.irq = st_q.match;
                            st_d.aph = st_q.match ? AP_DATA : AP_IDLE;
                        end
                        default: ;
                    endcase
                end
            end
        end

        if (!cfg.auto_ack)
            st_d.ack = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, irq: 1'b0, err: 1'b0, ack: 1'b0,
                      aph: AP_IDLE, match: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq       = st_q.irq;
    assign set_err   = st_q.err;
    assign ack_drive = st_q.ack;
endmodule

// File: rtl/sti_irq_gen_chk.sv
module sti_irq_gen_chk #(
    parameter int BYTE_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           ser_mode,
    input logic                 busy_en,
    input logic                 wake_en,
    input logic [1:0]           wt_sel,
    input logic                 ack_auto_en,
    input logic                 start_stb,
    input logic                 stop_stb,
    input logic [BYTE_BITS-1:0] rx_byte,
    input logic                 irq,
    input logic                 set_err,
    input logic                 ack_drive
);
    logic addr_cfg;
    assign addr_cfg = (ser_mode == 2'b10) && busy_en && wake_en &&
                      (wt_sel == 2'b11) && ack_auto_en;

    // R5: the request never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: an error flag and a request never appear together
    a_r4_err_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |-> !irq);

    // R4: the reserved mode is always flagged
    a_r4_rsvd_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode == 2'b11) |=> set_err);

    // R7: acknowledge only starts under receive mode with auto enable
    a_r7_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drive) |-> ($past(ser_mode) == 2'b10) && $past(ack_auto_en));

    // R1: plain serial mode never drives the acknowledge
    a_r1_sio_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode == 2'b00) |=> !ack_drive);

    // R9: a stop in address-match mode always requests
    a_r9_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_cfg && stop_stb && !start_stb) |=> irq);

    // R6: a start in the I2C modes suppresses the next request
    a_r6_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stb && ser_mode != 2'b00 && !set_err && !stop_stb &&
         $stable(ser_mode)) |=> !irq || set_err);
endmodule

bind sti_irq_gen sti_irq_gen_chk #(.BYTE_BITS(BYTE_BITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_mode    (ser_mode),
    .busy_en     (busy_en),
    .wake_en     (wake_en),
    .wt_sel      (wt_sel),
    .ack_auto_en (ack_auto_en),
    .start_stb   (start_stb),
    .stop_stb    (stop_stb),
    .rx_byte     (rx_byte),
    .irq         (irq),
    .set_err     (set_err),
    .ack_drive   (ack_drive)
);

// File: tb/sti_irq_gen_tb.sv
module sti_irq_gen_tb_top;
    localparam int BB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ser_mode = 2'b11;
    logic          busy_en = 1'b0, wake_en = 1'b0, ack_auto_en = 1'b0;
    logic [1:0]    wt_sel = 2'b00;
    logic          sclk_in = 1'b0, start_stb = 1'b0, stop_stb = 1'b0;
    logic [BB-1:0] rx_byte = 8'hA5, slave_addr = 8'hA5;
    logic          irq, set_err, ack_drive;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sti_irq_gen #(.BYTE_BITS(BB), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .busy_en(busy_en),
        .wake_en(wake_en), .wt_sel(wt_sel), .ack_auto_en(ack_auto_en),
        .sclk_in(sclk_in), .start_stb(start_stb), .stop_stb(stop_stb),
        .rx_byte(rx_byte), .slave_addr(slave_addr),
        .irq(irq), .set_err(set_err), .ack_drive(ack_drive)
    );

    always @(negedge clk) begin
        if (rst_n && irq) irq_seen <= irq_seen + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            sclk_in = 1'b1; tick(4);
            sclk_in = 1'b0; tick(4);
        end
    endtask

    task automatic do_start();
        start_stb = 1'b1; tick(1); start_stb = 1'b0; tick(1);
    endtask

    task automatic do_stop();
        stop_stb = 1'b1; tick(1); stop_stb = 1'b0; tick(2);
    endtask

    task automatic setc(input logic [1:0] m, input logic b, input logic w,
                        input logic [1:0] ws, input logic a);
        ser_mode = 2'b11; tick(2);
        ser_mode = m; busy_en = b; wake_en = w; wt_sel = ws; ack_auto_en = a;
        tick(2);
    endtask

    // Clocks per interrupt from the requirements: 0 means prohibited
    function automatic int per_irq(input logic [1:0] m, input logic b,
                                   input logic w, input logic [1:0] ws,
                                   input logic a);
        if (m == 2'b00) return (!b && !w && ws == 0 && !a) ? 8 : 0;
        if (m == 2'b01) return (!b && !w && !a && ws[1]) ? 8 + ws[0] : 0;
        if (m == 2'b10 && b && ws[1]) begin
            if (!w && !ws[0] && !a) return 8;
            if (!w && ws[0]) return 9;
            if (w && ws[0] && a) return 9;
        end
        return 0;
    endfunction

    initial begin
        int base;
        tick(3);
        chk("R4 reset irq", irq, 0);
        chk("R4 reset set_err", set_err, 0);
        chk("R7 reset ack", ack_drive, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R4 reserved mode flagged", set_err, 1);

        // Exhaustive sweep of all control settings (R1 R2 R3 R4 R8)
        for (int k = 0; k < 128; k++) begin
            logic [1:0] m  = k[6:5];
            logic       b  = k[4];
            logic       w  = k[3];
            logic [1:0] ws = k[2:1];
            logic       a  = k[0];
            int per = per_irq(m, b, w, ws, a);
            int exp;
            setc(m, b, w, ws, a);
            chk($sformatf("R4 set_err cfg=%0d", k), set_err, per == 0);
            do_start();
            base = irq_seen;
            pulse(17);
            exp = (per == 0) ? 0 : 17 / per;
            chk($sformatf("R1 R2 R3 R8 irq count cfg=%0d", k),
                irq_seen - base, exp);
        end

        // R5: exact timing of the pulse (transmit, 8 clocks)
        setc(2'b01, 0, 0, 2'b10, 0);
        do_start();
        pulse(7);
        sclk_in = 1'b1;
        tick(1); chk("R5 irq after edge 1", irq, 0);
        tick(1); chk("R5 irq after edge 2", irq, 0);
        tick(1); chk("R5 irq after edge 3", irq, 1);
        tick(1); chk("R5 irq one cycle only", irq, 0);
        sclk_in = 1'b0; tick(4);

        // R6: start clears the count in I2C mode
        do_start();
        base = irq_seen;
        pulse(5); do_start(); pulse(7);
        chk("R6 start clears count", irq_seen - base, 0);
        pulse(1);
        chk("R6 irq after full byte", irq_seen - base, 1);

        // R6: start ignored in plain serial mode
        setc(2'b00, 0, 0, 2'b00, 0);
        base = irq_seen;
        pulse(5); do_start(); pulse(3);
        chk("R6 start ignored in serial mode", irq_seen - base, 1);

        // R7: automatic acknowledge window
        setc(2'b10, 1, 0, 2'b11, 1);
        do_start();
        pulse(7);
        chk("R7 ack low before 8th", ack_drive, 0);
        pulse(1);
        chk("R7 ack high after 8th", ack_drive, 1);
        pulse(1);
        chk("R7 ack low after 9th", ack_drive, 0);
        setc(2'b10, 1, 0, 2'b11, 0);
        do_start();
        pulse(8);
        chk("R7 no ack when disabled", ack_drive, 0);

        // R9: stop ignored outside address-match mode
        base = irq_seen;
        do_stop();
        chk("R9 stop ignored", irq_seen - base, 0);

        // R8: mismatch ignores bytes until next start
        setc(2'b10, 1, 1, 2'b11, 1);
        slave_addr = 8'h3C;
        do_start();
        base = irq_seen;
        pulse(8);
        chk("R8 no ack on mismatch", ack_drive, 0);
        pulse(19);
        chk("R8 mismatch no irq", irq_seen - base, 0);

        // R9: stop raises a request in address-match mode
        do_stop();
        chk("R9 stop irq", irq_seen - base, 1);

        // R8: a matching address after a new start
        slave_addr = 8'hA5;
        do_start();
        base = irq_seen;
        pulse(8);
        chk("R8 ack on match", ack_drive, 1);
        pulse(1);
        chk("R8 irq on match", irq_seen - base, 1);
        pulse(9);
        chk("R8 data byte irq", irq_seen - base, 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule